// File: doc/BRIEF.md
# Configurable Watchdog Reset Timer

This block watches for software that has stopped running. Software must pulse a clear input more often than a programmed interval; when it fails to, the block raises a one-cycle reset request. The interval is a power of two between 2^9 and 2^24 ticks. The ticks come from one of three time bases, each delivered as a tick-enable pulse in the single system clock domain: an internal RC oscillator, the main oscillator and the sub oscillator.

Beyond the timeout, two other events can raise the request. In one of the two RC modes, a strobe signalling an RC frequency change triggers a reset. An enable bit makes entry into stop mode trigger a reset. An 8-bit configuration register holds these settings and is written and read through a plain register port.

The interval, time-base and stop fields sit at fixed bit positions, because software encodes them. Any write that changes the interval or the time base restarts the count, so a new setting always starts from a full period.

Top module: `wdt_reset_timer`

## Requirements
- R1: After reset, the configuration reads 0x00 and the reset request is low. This is interval code 0, RC time base with frequency changes tolerated, and stop-mode reset off.
- R2: A write stores data bits 6:0. Bit 7 always reads 0, whatever is written to it. The field layout is interval code in bits 3:0, time-base select in bits 5:4 and stop-mode reset enable in bit 6.
- R3: With interval code c (0..15), the reset request goes high for exactly one cycle. It does so in the cycle after the 2^(9+c)-th selected tick counted since the last restart. The count then starts again from zero.
- R4: A pulse on the clear input restarts the count from zero. A clear in the same cycle as the terminal tick prevents the request.
- R5: Only ticks of the selected time base are counted. Select values 00 and 01 choose the RC tick, 10 chooses the main tick and 11 chooses the sub tick.
- R6: A write that changes bits 5:0 restarts the count. A write that changes only bit 6 leaves the count running.
- R7: With select 01, a pulse on the RC frequency-change input raises the request in the next cycle, whatever the count. With any other select the pulse has no effect.
- R8: With bit 6 set, a stop-entry pulse raises the request in the next cycle. With bit 6 clear it has no effect.
- R9: The counter spans 24 bits, so code 15 runs for 2^24 ticks. No request appears after tens of thousands of ticks at that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Current configuration, bit 7 reads 0 |
| kick | input | 1 | Clear pulse from software, restarts the count |
| rc_tick | input | 1 | RC oscillator tick enable |
| main_tick | input | 1 | Main oscillator tick enable |
| sub_tick | input | 1 | Sub oscillator tick enable |
| rc_freq_chg | input | 1 | Strobe: RC oscillator frequency changed |
| stop_entry | input | 1 | Strobe: system is entering stop mode |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The timeout is driven with uninterrupted ticks at several interval codes, stopping one tick short and then reaching the limit. This separates an off-by-one terminal count from a correct one. The other time bases are then ticked while a different source is selected, which shows whether the tick selection is wired correctly. Clear pulses are placed mid-count and exactly on the terminal tick, and writes are made with and without field changes; these show the restart conditions. The frequency-change and stop strobes are applied in every relevant mode, so that an enable decoded from the wrong bit or value shows up as a missing or spurious request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int IVL_W    = 4;
  localparam int BASE_EXP = 9;
  localparam int CFG_W    = 8;
  localparam int CNT_W    = BASE_EXP + (1 << IVL_W) - 1;

  typedef enum logic [1:0] {
    CS_RC_TOL    = 2'b00,
    CS_RC_STRICT = 2'b01,
    CS_MAIN      = 2'b10,
    CS_SUB       = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic                 stop_rst_en;
    clk_src_e             src;
    logic [IVL_W-1:0]     interval;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output wdt_cfg_t         cfg,
  output logic             restart_req,
  output logic [CFG_W-1:0] rd_data
);
  wdt_cfg_t nxt;
  logic     unused_rsvd;

  assign nxt         = wdt_cfg_t'(wr_data[CFG_W-2:0]);
  assign unused_rsvd = wr_data[CFG_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= nxt;
  end

  assign restart_req = wr_en && ({nxt.src, nxt.interval} != {cfg.src, cfg.interval});
  assign rd_data     = {1'b0, cfg};

  // R2: written bits appear in the register one cycle later
  p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CFG_W-2:0] == $past(wr_data[CFG_W-2:0])));
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
(
  input  clk_src_e src,
  input  logic     rc_tick,
  input  logic     main_tick,
  input  logic     sub_tick,
  output logic     tick
);
  always_comb begin
    unique case (src)
      CS_RC_TOL, CS_RC_STRICT: tick = rc_tick;
      CS_MAIN:                 tick = main_tick;
      default:                 tick = sub_tick;
    endcase
  end
endmodule

// File: rtl/wdt_interval_counter.sv
module wdt_interval_counter #(
  parameter int IVL_W    = 4,
  parameter int BASE_EXP = 9,
  localparam int NCODE   = 1 << IVL_W,
  localparam int CNT_W   = BASE_EXP + NCODE - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [IVL_W-1:0] interval,
  output logic             expire
);
  logic [CNT_W-1:0] count;
  logic [NCODE-1:0] at_last;
  logic             last;

  for (genvar k = 0; k < NCODE; k++) begin : g_term
    assign at_last[k] = (count == CNT_W'((64'd1 << (BASE_EXP + k)) - 64'd1));
  end

  assign last   = at_last[interval];
  assign expire = tick && last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (tick)    count <= last ? '0 : count + 1'b1;
  end

  // R4: a restart leaves the count at zero
  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));
  // R5: no selected tick, no movement
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));
  // R9: count never passes the selected terminal value
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'((64'd1 << (BASE_EXP + int'(interval))) - 64'd1));
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             kick,
  input  logic             rc_tick,
  input  logic             main_tick,
  input  logic             sub_tick,
  input  logic             rc_freq_chg,
  input  logic             stop_entry,
  output logic             wdt_rst_req
);
  wdt_cfg_t cfg;
  logic     cfg_restart, restart, tick, expire, freq_evt, stop_evt;

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg(cfg), .restart_req(cfg_restart), .rd_data(cfg_rd_data)
  );

  wdt_tick_sel u_sel (
    .src(cfg.src), .rc_tick(rc_tick), .main_tick(main_tick),
    .sub_tick(sub_tick), .tick(tick)
  );

  assign restart = kick || cfg_restart;

  wdt_interval_counter #(.IVL_W(IVL_W), .BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .interval(cfg.interval), .expire(expire)
  );

  assign freq_evt = rc_freq_chg && (cfg.src == CS_RC_STRICT);
  assign stop_evt = stop_entry && cfg.stop_rst_en;

  always_ff @(posedge clk) begin
    if (!rst_n) wdt_rst_req <= 1'b0;
    else        wdt_rst_req <= expire || freq_evt || stop_evt;
  end

  // R3: terminal tick raises the request next cycle
  p_timeout_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wdt_rst_req);
  // R7: strict RC mode reacts to a frequency change
  p_freq_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_freq_chg && cfg_rd_data[5:4] == 2'b01) |=> wdt_rst_req);
  // R8: stop entry with the enable set
  p_stop_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_entry && cfg_rd_data[6]) |=> wdt_rst_req);
endmodule

// File: tb/tb_wdt_reset_timer.sv
`timescale 1ns/1ps
module tb_wdt_reset_timer;
  logic       clk = 0, rst_n = 0;
  logic       cfg_wr_en = 0, kick = 0, rc_tick = 0, main_tick = 0, sub_tick = 0;
  logic       rc_freq_chg = 0, stop_entry = 0;
  logic [7:0] cfg_wr_data = 0;
  logic [7:0] cfg_rd_data;
  logic       wdt_rst_req;

  always #2 clk = ~clk;

  wdt_reset_timer dut (.*);

  int    n_chk = 0, n_fail = 0, total_pulses = 0, snap = 0;
  string tag = "R1";

  // behavioural reference: ticks since restart, compared to 2^(9+code)
  logic [6:0] m_cfg = 0;
  int         m_ticks = 0;
  bit         m_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_ticks = 0; m_req = 0;
    end else begin
      int  limit;
      bit  t, ev;
      limit = 1 << (9 + m_cfg[3:0]);
      case (m_cfg[5:4])
        2'd2:    t = main_tick;
        2'd3:    t = sub_tick;
        default: t = rc_tick;
      endcase
      ev = 0;
      if (kick || (cfg_wr_en && cfg_wr_data[5:0] != m_cfg[5:0])) m_ticks = 0;
      else if (t) begin
        m_ticks++;
        if (m_ticks == limit) begin ev = 1; m_ticks = 0; end
      end
      if (rc_freq_chg && m_cfg[5:4] == 2'd1) ev = 1;
      if (stop_entry && m_cfg[6]) ev = 1;
      m_req = ev;
      if (cfg_wr_en) m_cfg = cfg_wr_data[6:0];
    end
  end

  task automatic check(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, "cycle req", int'(wdt_rst_req), int'(m_req));
      check(tag, "cycle rd_data", int'(cfg_rd_data), int'({1'b0, m_cfg}));
      if (wdt_rst_req) total_pulses++;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic wr(input logic [7:0] d);
    cfg_wr_en = 1; cfg_wr_data = d; step(); cfg_wr_en = 0;
  endtask
  task automatic run(input int which, input int n);
    if (which == 0) rc_tick = 1; else if (which == 1) main_tick = 1; else sub_tick = 1;
    repeat (n) step();
    rc_tick = 0; main_tick = 0; sub_tick = 0;
  endtask
  task automatic mark(); snap = total_pulses; endtask
  task automatic expect_pulses(input string r, input int exp);
    repeat (3) step();
    check(r, "pulse count", total_pulses - snap, exp);
    snap = total_pulses;
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1; step();
    // R1
    tag = "R1";
    check("R1", "reset rd_data", int'(cfg_rd_data), 0);
    check("R1", "reset req", int'(wdt_rst_req), 0);
    // R2
    tag = "R2";
    wr(8'hFF); step();
    check("R2", "bit7 reads 0", int'(cfg_rd_data), 8'h7F);
    wr(8'h00); step();
    check("R2", "cleared", int'(cfg_rd_data), 0);
    // R3
    tag = "R3"; wr(8'h00); mark();
    run(0, 512); expect_pulses("R3", 1);
    wr(8'h02); run(0, 2047); expect_pulses("R3", 0);
    run(0, 1); expect_pulses("R3", 1);
    // R4
    tag = "R4"; wr(8'h00); mark();
    run(0, 300); kick = 1; step(); kick = 0;
    run(0, 300); expect_pulses("R4", 0);
    run(0, 212); expect_pulses("R4", 1);
    rc_tick = 1; repeat (511) step(); kick = 1; step(); kick = 0; rc_tick = 0;
    expect_pulses("R4", 0);
    // R5
    tag = "R5";
    wr(8'h20); run(0, 600); expect_pulses("R5", 0);
    run(1, 512); expect_pulses("R5", 1);
    wr(8'h30); run(1, 600); expect_pulses("R5", 0);
    run(2, 512); expect_pulses("R5", 1);
    wr(8'h10); run(0, 512); expect_pulses("R5", 1);
    // R6
    tag = "R6";
    wr(8'h00); run(0, 400); wr(8'h40); run(0, 112); expect_pulses("R6", 1);
    wr(8'h00); run(0, 400); wr(8'h01); run(0, 1023); expect_pulses("R6", 0);
    run(0, 1); expect_pulses("R6", 1);
    // R7
    tag = "R7";
    wr(8'h00); rc_freq_chg = 1; step(); rc_freq_chg = 0; expect_pulses("R7", 0);
    wr(8'h10); rc_freq_chg = 1; step(); rc_freq_chg = 0; expect_pulses("R7", 1);
    wr(8'h20); rc_freq_chg = 1; step(); rc_freq_chg = 0; expect_pulses("R7", 0);
    // R8
    tag = "R8";
    wr(8'h40); stop_entry = 1; step(); stop_entry = 0; expect_pulses("R8", 1);
    wr(8'h00); stop_entry = 1; step(); stop_entry = 0; expect_pulses("R8", 0);
    // R9
    tag = "R9";
    wr(8'h0F); run(0, 70000); expect_pulses("R9", 0);
    check("R9", "rd_data code 15", int'(cfg_rd_data), 8'h0F);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule